// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter with a three-and-a-half digit decimal result. It divides the oscillator clock into count ticks and runs a fixed-length conversion frame. A frame has three phases: offset nulling (auto-zero), integration of the input for a fixed number of counts, and integration of a reference of opposite sign until the integrator comes back to zero. The phase outputs drive the analog switch network. The reference sign output selects which reference polarity is applied during the run-down phase.

The run-down time is measured by a chain of decimal decade counters. The integrator's return to zero is seen as the single comparator input changing state relative to the level it had when integration ended. At the end of the run-down the count, a negative-sign flag and an overrange flag move into an output register together, and a one-cycle strobe marks the update. The display never shows a count that is still in progress. Auto-zero takes whatever counts the run-down left unused, so frames start at a fixed rate whatever the input.

Top module: `dual_slope_seq`

## Requirements
- R1: Phases and counters advance only on count ticks, one every DIV_RATIO clocks (default 4); the first tick comes on the DIV_RATIO-th rising edge after reset is released.
- R2: Exactly one of `az_o`, `int_o`, `dei_o` is high at all times. The order is always auto-zero, then integrate, then run-down, then auto-zero again.
- R3: The integrate phase lasts exactly INT_COUNTS counts (default 1000), that is INT_COUNTS×DIV_RATIO clocks.
- R4: Integrate starts exactly FRAME_COUNTS counts apart (default 4000). Run-down lasts at most RUN_MAX counts (default 2000). Auto-zero fills the rest of the frame. The first auto-zero after reset lasts a full FRAME_COUNTS.
- R5: `ref_neg_o` takes the value of `cmp_i` sampled on the last integrate tick and holds it for the whole run-down. A value of 1 means a positive input was integrated and the negative reference is applied.
- R6: Run-down ends on the first tick at which `cmp_i` differs from the sampled level. The result is the number of run-down ticks before that tick, so run-down lasts result+1 counts. `rd_bcd_o` holds it as decimal digits, with units in bits [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12].
- R7: If no crossing has occurred when the counter holds RUN_MAX−1, that tick ends the run-down. RUN_MAX−1 is latched with `rd_over_o`=1. A crossing on that same tick takes priority and latches RUN_MAX−1 with `rd_over_o`=0.
- R8: `rd_neg_o` is latched as 1 when `cmp_i` was 0 at the end of integration (negative input) and as 0 otherwise.
- R9: `rd_bcd_o`, `rd_neg_o` and `rd_over_o` change only in the clock where `rd_valid_o` is high. `rd_valid_o` is a single-cycle pulse following the tick that ends the run-down.
- R10: A synchronous active-high `rst` gives auto-zero, a cleared counter and frame position, zero results, `rd_valid_o`=0 and `ref_neg_o`=0, including when it is asserted during run-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Integrator comparator, 1 = integrator on the positive side (synchronous) |
| az_o | output | 1 | Auto-zero phase switch control |
| int_o | output | 1 | Signal integrate phase switch control |
| dei_o | output | 1 | Run-down (reference integrate) phase switch control |
| ref_neg_o | output | 1 | Reference polarity select for run-down, 1 = negative reference |
| rd_bcd_o | output | 4*NUM_DIGITS | Latched result, decimal digits, units in lowest nibble |
| rd_neg_o | output | 1 | Latched sign, 1 = negative input |
| rd_over_o | output | 1 | Latched overrange flag |
| rd_valid_o | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The hardest conditions to reach are the two run-down endings at the counter limit: a crossing that arrives on exactly the tick where the counter holds RUN_MAX−1, and a run-down that never crosses. The bench models the integrator with a signed input level given in counts. It flips the comparator a computed number of clocks after it sees the run-down output rise. This lets a chosen input land on the limit tick exactly, or stay beyond it for an overrange. The parameters are scaled down so that many full frames, a thousands-digit carry and a reset during run-down fit in the run. A behavioural model is compared against every output on every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [1:0] {
      PH_AZ  = 2'd0,
      PH_INT = 2'd1,
      PH_DE  = 2'd2
   } phase_e;

   // Binary to packed decimal, up to 16 digits, units in the lowest nibble.
   function automatic logic [63:0] to_bcd(input int unsigned v);
      logic [63:0]  r;
      int unsigned  t;
      r = '0;
      t = v;
      for (int i = 0; i < 16; i++) begin
         r[4*i +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

endpackage

// File: rtl/dsc_prescaler.sv
module dsc_prescaler #(
   parameter int DIV_RATIO = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

   generate
      if (DIV_RATIO < 1) begin : g_bad_div
         $error("dsc_prescaler: DIV_RATIO must be at least 1");
      end

      if (DIV_RATIO == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt <= '0;
            end else if (cnt == PW'(DIV_RATIO - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = (cnt == PW'(DIV_RATIO - 1));

         // Ticks are never back to back when dividing.
         p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
   parameter int NUM_DIGITS = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    inc,
   output logic [4*NUM_DIGITS-1:0] value
);
   logic [NUM_DIGITS:0] carry;

   assign carry[0] = inc;

   generate
      if (NUM_DIGITS < 1) begin : g_bad_nd
         $error("dsc_bcd_counter: NUM_DIGITS must be at least 1");
      end

      for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_decade
         logic [3:0] dig;

         always_ff @(posedge clk) begin
            if (rst || clr) begin
               dig <= 4'd0;
            end else if (carry[i]) begin
               dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
            end
         end

         assign carry[i+1]      = carry[i] && (dig == 4'd9);
         assign value[4*i +: 4] = dig;

         p_digit_dec_r6: assert property (@(posedge clk) disable iff (rst)
            dig <= 4'd9);
      end
   endgenerate

   // The chain never rolls over past its top digit.
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      !carry[NUM_DIGITS]);

endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
   import dsc_pkg::*;
#(
   parameter int INT_COUNTS   = 1000,
   parameter int RUN_MAX      = 2000,
   parameter int FRAME_COUNTS = 4000
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   tick,
   input  logic   cmp_i,
   input  logic   at_max,
   output phase_e phase,
   output logic   pol_q,
   output logic   cnt_clr,
   output logic   cnt_inc,
   output logic   done,
   output logic   over
);
   localparam int FW = $clog2(FRAME_COUNTS);

   logic [FW-1:0] fpos;
   logic          frame_last;
   logic          int_last;
   logic          crossed;

   assign frame_last = (fpos == FW'(FRAME_COUNTS - 1));
   assign int_last   = (fpos == FW'(INT_COUNTS - 1));
   assign crossed    = (cmp_i != pol_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_AZ;
         fpos  <= '0;
         pol_q <= 1'b0;
      end else if (tick) begin
         fpos <= frame_last ? '0 : fpos + 1'b1;
         case (phase)
            PH_AZ: begin
               if (frame_last) phase <= PH_INT;
            end
            PH_INT: begin
               if (int_last) begin
                  phase <= PH_DE;
                  pol_q <= cmp_i;
               end
            end
            PH_DE: begin
               if (crossed || at_max) phase <= PH_AZ;
            end
            default: phase <= PH_AZ;
         endcase
      end
   end

   assign cnt_clr = tick && (phase == PH_INT) && int_last;
   assign cnt_inc = tick && (phase == PH_DE) && !crossed && !at_max;
   assign done    = tick && (phase == PH_DE) && (crossed || at_max);
   assign over    = done && !crossed;

   p_move_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(phase));

   p_int_window_r3: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_INT) |-> (fpos < FW'(INT_COUNTS)));

   p_de_window_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_DE) |-> ((fpos >= FW'(INT_COUNTS)) &&
                            (fpos < FW'(INT_COUNTS + RUN_MAX))));

   p_az_after_de_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(phase) == PH_DE && phase != PH_DE) |-> (phase == PH_AZ));

   p_int_after_az_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(phase) != PH_INT && phase == PH_INT) |-> ($past(phase) == PH_AZ));

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
   import dsc_pkg::*;
#(
   parameter int DIV_RATIO    = 4,
   parameter int INT_COUNTS   = 1000,
   parameter int RUN_MAX      = 2000,
   parameter int FRAME_COUNTS = 4000,
   parameter int NUM_DIGITS   = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cmp_i,
   output logic                    az_o,
   output logic                    int_o,
   output logic                    dei_o,
   output logic                    ref_neg_o,
   output logic [4*NUM_DIGITS-1:0] rd_bcd_o,
   output logic                    rd_neg_o,
   output logic                    rd_over_o,
   output logic                    rd_valid_o
);
   localparam int DW = 4 * NUM_DIGITS;
   localparam logic [DW-1:0] MAX_BCD = DW'(to_bcd(RUN_MAX - 1));

   generate
      if (NUM_DIGITS < 1 || NUM_DIGITS > 9) begin : g_bad_digits
         $error("dual_slope_seq: NUM_DIGITS out of range 1..9");
      end
      if (INT_COUNTS < 1 || RUN_MAX < 1) begin : g_bad_counts
         $error("dual_slope_seq: phase lengths must be positive");
      end
      if (FRAME_COUNTS <= INT_COUNTS + RUN_MAX) begin : g_bad_frame
         $error("dual_slope_seq: frame leaves no auto-zero time");
      end
      if (RUN_MAX - 1 >= 10 ** NUM_DIGITS) begin : g_bad_range
         $error("dual_slope_seq: RUN_MAX does not fit the digits");
      end
   endgenerate

   logic          tick;
   phase_e        phase;
   logic          pol_q;
   logic          cnt_clr;
   logic          cnt_inc;
   logic          done;
   logic          over;
   logic          at_max;
   logic [DW-1:0] cnt_bcd;

   dsc_prescaler #(
      .DIV_RATIO (DIV_RATIO)
   ) u_presc (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   dsc_phase_ctrl #(
      .INT_COUNTS   (INT_COUNTS),
      .RUN_MAX      (RUN_MAX),
      .FRAME_COUNTS (FRAME_COUNTS)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .cmp_i   (cmp_i),
      .at_max  (at_max),
      .phase   (phase),
      .pol_q   (pol_q),
      .cnt_clr (cnt_clr),
      .cnt_inc (cnt_inc),
      .done    (done),
      .over    (over)
   );

   dsc_bcd_counter #(
      .NUM_DIGITS (NUM_DIGITS)
   ) u_count (
      .clk   (clk),
      .rst   (rst),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .value (cnt_bcd)
   );

   assign at_max = (cnt_bcd == MAX_BCD);

   // Result register: loaded once per frame, on the tick ending run-down.
   always_ff @(posedge clk) begin
      if (rst) begin
         rd_bcd_o   <= '0;
         rd_neg_o   <= 1'b0;
         rd_over_o  <= 1'b0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_valid_o <= done;
         if (done) begin
            rd_bcd_o  <= cnt_bcd;
            rd_neg_o  <= !pol_q;
            rd_over_o <= over;
         end
      end
   end

   assign az_o      = (phase == PH_AZ);
   assign int_o     = (phase == PH_INT);
   assign dei_o     = (phase == PH_DE);
   assign ref_neg_o = pol_q;

   p_onehot_phase_r2: assert property (@(posedge clk) disable iff (rst)
      $countones({az_o, int_o, dei_o}) == 1);

   p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      rd_valid_o |=> !rd_valid_o);

   p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !rd_valid_o |-> ($stable(rd_bcd_o) && $stable(rd_neg_o) && $stable(rd_over_o)));

   p_over_value_r7: assert property (@(posedge clk) disable iff (rst)
      rd_over_o |-> (rd_bcd_o == MAX_BCD));

   p_ref_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (dei_o && $past(dei_o)) |-> $stable(ref_neg_o));

endmodule

// File: tb/tb_dual_slope_seq.sv
module tb_dual_slope_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 4;
   localparam int INTC  = 500;
   localparam int DMAX  = 1200;
   localparam int FRAME = 2400;
   localparam int ND    = 4;
   localparam int NSTIM = 8;
   localparam int WATCHDOG = 190000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmp = 1'b1;
   logic az, intg, dei, refn, rneg, rover, rvalid;
   logic [4*ND-1:0] rbcd;

   dual_slope_seq #(
      .DIV_RATIO (DIV), .INT_COUNTS (INTC), .RUN_MAX (DMAX),
      .FRAME_COUNTS (FRAME), .NUM_DIGITS (ND)
   ) dut (
      .clk (clk), .rst (rst), .cmp_i (cmp),
      .az_o (az), .int_o (intg), .dei_o (dei), .ref_neg_o (refn),
      .rd_bcd_o (rbcd), .rd_neg_o (rneg), .rd_over_o (rover),
      .rd_valid_o (rvalid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [4*ND-1:0] int_to_bcd(input int v);
      logic [4*ND-1:0] r;
      int t;
      t = v;
      for (int i = 0; i < ND; i++) begin
         r[4*i +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   function automatic int bcd_to_int(input logic [4*ND-1:0] b);
      int r;
      int w;
      r = 0;
      w = 1;
      for (int i = 0; i < ND; i++) begin
         r = r + int'(b[4*i +: 4]) * w;
         w = w * 10;
      end
      return r;
   endfunction

   // Input levels in counts, and their signs (1 = positive).
   int stim_n [NSTIM] = '{0, 123, 456, 1199, 5000, 1000, 7, 999};
   bit stim_p [NSTIM] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   // Behavioural reference: phase 0 = auto-zero, 1 = integrate, 2 = run-down.
   int m_pre = 0, m_fpos = 0, m_ph = 0, m_cnt = 0;
   bit m_pol = 0, m_dneg = 0, m_dover = 0, m_eoc = 0;
   int m_dval = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_pre = 0; m_fpos = 0; m_ph = 0; m_cnt = 0; m_pol = 0;
         m_dval = 0; m_dneg = 0; m_dover = 0; m_eoc = 0;
      end else begin
         bit tk;
         tk = (m_pre == DIV - 1);
         m_pre = tk ? 0 : m_pre + 1;
         m_eoc = 0;
         if (tk) begin
            if (m_ph == 0) begin
               if (m_fpos == FRAME - 1) m_ph = 1;
            end else if (m_ph == 1) begin
               if (m_fpos == INTC - 1) begin
                  m_ph = 2; m_pol = cmp; m_cnt = 0;
               end
            end else begin
               if (cmp != m_pol) begin
                  m_dval = m_cnt; m_dover = 0; m_dneg = !m_pol; m_eoc = 1; m_ph = 0;
               end else if (m_cnt == DMAX - 1) begin
                  m_dval = m_cnt; m_dover = 1; m_dneg = !m_pol; m_eoc = 1; m_ph = 0;
               end else begin
                  m_cnt++;
               end
            end
            m_fpos = (m_fpos == FRAME - 1) ? 0 : m_fpos + 1;
         end
      end
   end

   int  cyc = 0;
   bit  timeout = 0;
   int  idx = 0;
   int  de_clk = 0;
   bit  prev_de = 0, prev_int = 0;
   int  last_int = 0;
   bit  have_int = 0;
   int  cur_n;
   bit  cur_p;

   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) timeout = 1;
      cur_n = (idx < NSTIM) ? stim_n[idx] : 300;
      cur_p = (idx < NSTIM) ? stim_p[idx] : 1'b1;
      if (!rst) begin
         // Per-clock comparison against the reference.
         check(az == (m_ph == 0) && intg == (m_ph == 1) && dei == (m_ph == 2),
               "R2", "phase", {29'd0, dei, intg, az}, 1 << m_ph);
         check(refn == m_pol, "R5", "ref_neg", int'(refn), int'(m_pol));
         check(rbcd == int_to_bcd(m_dval), "R6", "result", bcd_to_int(rbcd), m_dval);
         check(rneg == m_dneg, "R8", "sign", int'(rneg), int'(m_dneg));
         check(rover == m_dover, "R7", "overrange", int'(rover), int'(m_dover));
         check(rvalid == m_eoc, "R9", "strobe", int'(rvalid), int'(m_eoc));

         // Phase timing measured at the ports.
         if (intg && !prev_int) begin
            if (have_int)
               check(cyc - last_int == DIV * FRAME, "R4", "frame clocks",
                     cyc - last_int, DIV * FRAME);
            last_int = cyc;
            have_int = 1;
         end
         if (!intg && prev_int)
            check(cyc - last_int == DIV * INTC, "R1 R3", "integrate clocks",
                  cyc - last_int, DIV * INTC);
         if (dei && !prev_de)
            check(refn == cur_p, "R5", "reference select at run-down", int'(refn), int'(cur_p));
         if (!dei && prev_de) begin
            int lim;
            lim = (cur_n > DMAX - 1) ? DMAX - 1 : cur_n;
            check(de_clk + 1 == DIV * (lim + 1), "R6", "run-down clocks",
                  de_clk + 1, DIV * (lim + 1));
         end

         // Result check straight from the stimulus.
         if (rvalid && idx < NSTIM) begin
            int ev;
            bit eo;
            ev = (cur_n > DMAX - 1) ? DMAX - 1 : cur_n;
            eo = (cur_n > DMAX - 1);
            check(rbcd == int_to_bcd(ev), eo ? "R7" : "R6", "latched reading",
                  bcd_to_int(rbcd), ev);
            check(rover == eo, "R7", "latched overrange", int'(rover), int'(eo));
            check(rneg == !cur_p, "R8", "latched sign", int'(rneg), int'(!cur_p));
            idx++;
            cur_n = (idx < NSTIM) ? stim_n[idx] : 300;
            cur_p = (idx < NSTIM) ? stim_p[idx] : 1'b1;
         end
      end

      // Integrator model: comparator flips cur_n counts into run-down.
      if (dei && !prev_de) de_clk = 0;
      else if (dei) de_clk++;
      if (dei && de_clk >= DIV * cur_n) cmp = !cur_p;
      else cmp = cur_p;
      prev_de  = dei;
      prev_int = intg;
   end

   task automatic check_reset_state(input string what);
      check(az && !intg && !dei, "R10", {what, " phase"}, {29'd0, dei, intg, az}, 1);
      check(rbcd == '0 && !rneg && !rover, "R10", {what, " result"}, bcd_to_int(rbcd), 0);
      check(!rvalid && !refn, "R10", {what, " strobe/ref"}, int'(rvalid) + 2 * int'(refn), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check_reset_state("initial reset");
      rst = 1'b0;
      // R1: nothing moves before the first tick.
      repeat (DIV - 1) @(negedge clk);
      check(az && !intg, "R1", "before first tick", int'(az), 1);

      wait (idx >= NSTIM || timeout);
      if (!timeout) begin
         while (!dei && !timeout) @(negedge clk);
         repeat (40) @(negedge clk);
         rst = 1'b1;
         repeat (2) @(negedge clk);
         check_reset_state("reset during run-down");
         rst = 1'b0;
         repeat (20) @(negedge clk);
      end
      if (timeout) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule